// File: doc/BRIEF.md
# Double-Precision to Unsigned 64-bit Integer Converter

This block turns one IEEE-754 binary64 value into an unsigned 64-bit integer. A 2-bit rounding code is supplied with each operand. The conversion is computed combinationally and captured in one output register stage. Each result therefore appears one clock after its operand and rounding code were presented. A new operand may be presented every cycle.

Alongside the integer, two flags are produced. The invalid flag marks a value that has no unsigned 64-bit representation: NaN, infinity, a value too large, or a negative value that rounds to minus one or below. In that case the result is forced to all ones, because trapping is never taken. The inexact flag marks a valid result that lost nonzero fraction bits. Normal numbers, subnormal numbers, signed zeros, infinities and NaNs are all handled.

Top module: `dbl2uint64_cvt`

## Requirements
- R1: The outputs `result`, `invalid` and `inexact` are registered and reflect the `operand` and `rmode` sampled on the previous rising clock edge. While `rst_n` is low, all three outputs are zero.
- R2: When fraction bits are discarded, the rounding code selects how the result is rounded: 2'b00 rounds to nearest with ties to even, 2'b01 rounds toward minus infinity, 2'b10 rounds toward plus infinity, and 2'b11 truncates toward zero. For example, 2.5 gives 2, 2, 3 and 2 under these four codes, and 3.5 gives 4 under 2'b00.
- R3: Whenever `invalid` is high, `result` equals 64'hFFFF_FFFF_FFFF_FFFF.
- R4: An operand whose exponent field (bits 62:52) is all ones is invalid, whatever its sign and fraction (infinity or NaN).
- R5: A positive operand whose rounded value is 2^64 or more is invalid. The largest double below 2^64 (64'h43EF_FFFF_FFFF_FFFF) converts exactly to 64'hFFFF_FFFF_FFFF_F800.
- R6: A negative operand that rounds to zero returns 0, with `inexact` set if it was not an exact zero. A negative operand whose rounded value is -1 or below is invalid.
- R7: Both signed zeros return 0 with no flag raised. A subnormal operand (exponent field zero, fraction nonzero) returns 0 with `inexact` set, with two exceptions: a positive subnormal under code 2'b10 returns 1, and a negative subnormal under code 2'b01 is invalid.
- R8: `inexact` is high only for a valid result whose discarded fraction was nonzero. It is never high together with `invalid`.
- R9: A non-negative operand that is an integer below 2^64 converts to that integer, with both flags low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| operand | input | 64 | Binary64 value to convert |
| rmode | input | 2 | Rounding code: 00 nearest-even, 01 toward minus infinity, 10 toward plus infinity, 11 toward zero |
| result | output | 64 | Unsigned integer result; all ones when invalid |
| invalid | output | 1 | The value has no unsigned 64-bit representation |
| inexact | output | 1 | A valid result was rounded |

## Verification
The block holds no state apart from its output register. A fault in the alignment shift or the round-increment logic therefore shows up one cycle later, as a result off by one or by a power of two, or as a wrong inexact flag, on that same operand. Random operands with exponents near the integer range are mixed with directed ties, boundaries at 2^64 and subnormal cases. This exposes such a fault within a few vectors. The main risk is a mis-sized shift clamp or overflow bound, and that would show up only at the directed boundary values.

// File: rtl/dbl2uint64_cvt.sv
module dbl2uint64_cvt (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [63:0] operand,
  input  logic [1:0]  rmode,
  output logic [63:0] result,
  output logic        invalid,
  output logic        inexact
);
  localparam int unsigned MW = 53;
  localparam logic [10:0] BIAS_INT = 11'd1075;
  localparam logic [10:0] OVF_EXP  = 11'd1087;
  localparam logic [5:0]  RSH_MAX  = 6'd55;

  logic        sgn;
  logic [10:0] ex;
  logic [51:0] fr;
  assign sgn = operand[63];
  assign ex  = operand[62:52];
  assign fr  = operand[51:0];

  logic        special, big, too_big;
  logic [10:0] e_eff, ldiff, rdiff;
  logic [MW-1:0] mant;
  assign special = &ex;
  assign e_eff   = (ex == 11'd0) ? 11'd1 : ex;
  assign mant    = {ex != 11'd0, fr};
  assign big     = e_eff >= BIAS_INT;
  assign too_big = e_eff >= OVF_EXP;
  assign ldiff   = e_eff - BIAS_INT;
  assign rdiff   = BIAS_INT - e_eff;

  logic [5:0]          rsh;
  logic [MW+63:0]      wide;
  logic [63:0]         ip, mag_rnd, mag_int, mag;
  logic                rbit, sbit, inc, frac_nz, inv_c, inx_c;

  always_comb begin
    rsh     = (rdiff > {5'd0, RSH_MAX}) ? RSH_MAX : rdiff[5:0];
    wide    = {mant, 64'd0} >> rsh;
    ip      = {11'd0, wide[MW+63:64]};
    rbit    = wide[63];
    sbit    = |wide[62:0];
    frac_nz = rbit | sbit;
    unique case (rmode)
      2'b00:   inc = rbit & (sbit | ip[0]);
      2'b01:   inc = sgn & frac_nz;
      2'b10:   inc = ~sgn & frac_nz;
      default: inc = 1'b0;
    endcase
    mag_rnd = ip + {63'd0, inc};
    mag_int = {11'd0, mant} << ldiff[3:0];
    mag     = big ? mag_int : mag_rnd;
    inv_c   = special | too_big | (sgn & (mag != 64'd0));
    inx_c   = ~inv_c & ~big & frac_nz;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result  <= 64'd0;
      invalid <= 1'b0;
      inexact <= 1'b0;
    end else begin
      result  <= inv_c ? {64{1'b1}} : (sgn ? 64'd0 : mag);
      invalid <= inv_c;
      inexact <= inx_c;
    end
  end
endmodule

module dbl2uint64_cvt_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [63:0] operand,
  input logic [1:0]  rmode,
  input logic [63:0] result,
  input logic        invalid,
  input logic        inexact
);
  assert_allones_on_invalid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    invalid |-> (result == {64{1'b1}}));

  assert_flags_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(invalid && inexact));

  assert_special_invalid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && ($past(operand[62:52]) == 11'h7FF)) |-> invalid);

  assert_zero_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && ($past(operand[62:0]) == 63'd0)) |-> (result == 64'd0 && !invalid && !inexact));

  assert_subnormal_small_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(operand[62:52]) == 11'd0 && $past(operand[51:0]) != 52'd0)
      |-> ((inexact && result <= 64'd1) || invalid));

  assert_truncate_no_inc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(rmode) == 2'b11 && $past(operand[63]) && !invalid) |-> (result == 64'd0));

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |-> (result == 64'd0 && !invalid && !inexact));
endmodule

bind dbl2uint64_cvt dbl2uint64_cvt_chk u_chk (
  .clk(clk), .rst_n(rst_n), .operand(operand), .rmode(rmode),
  .result(result), .invalid(invalid), .inexact(inexact)
);

// File: tb/dbl2uint64_cvt_bench.sv
module dbl2uint64_cvt_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] operand = 64'd0;
  logic [1:0]  rmode = 2'b00;
  logic [63:0] result;
  logic        invalid, inexact;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  dbl2uint64_cvt u_dbl2uint64_cvt (
    .clk(clk), .rst_n(rst_n), .operand(operand), .rmode(rmode),
    .result(result), .invalid(invalid), .inexact(inexact)
  );

  function automatic logic [65:0] ref_cvt(input logic [63:0] op, input logic [1:0] rm);
    logic s; logic [10:0] e; logic [52:0] m; int sh;
    logic [127:0] fx; logic [63:0] ipart, frac; logic [64:0] v; logic up, inv, inx;
    s = op[63]; e = op[62:52];
    m = {e != 0, op[51:0]};
    if (e == 11'h7FF) return {64'hFFFF_FFFF_FFFF_FFFF, 2'b10};
    if (e >= 11'd1087) return {64'hFFFF_FFFF_FFFF_FFFF, 2'b10};
    sh = int'((e == 0) ? 11'd1 : e) - 1075 + 64;
    if (m == 0) fx = 128'd0;
    else if (sh < 0) fx = 128'd1;
    else fx = {75'd0, m} << sh;
    ipart = fx[127:64]; frac = fx[63:0];
    inx = (frac != 0);
    case (rm)
      2'b00: up = (frac > 64'h8000_0000_0000_0000) ||
                  (frac == 64'h8000_0000_0000_0000 && ipart[0]);
      2'b01: up = s && inx;
      2'b10: up = !s && inx;
      default: up = 1'b0;
    endcase
    v = {1'b0, ipart} + {64'd0, up};
    inv = v[64] || (s && v != 0);
    if (inv) return {64'hFFFF_FFFF_FFFF_FFFF, 2'b10};
    return {s ? 64'd0 : v[63:0], 1'b0, inx};
  endfunction

  task automatic apply(input logic [63:0] op, input logic [1:0] rm, input string tag);
    logic [65:0] exp_v;
    @(negedge clk);
    operand = op; rmode = rm;
    exp_v = ref_cvt(op, rm);
    @(negedge clk);
    checks++;
    if ({result, invalid, inexact} !== exp_v) begin
      fails++;
      $display("FAIL %s op=%h rm=%0d got res=%h inv=%b inx=%b exp res=%h inv=%b inx=%b",
               tag, op, rm, result, invalid, inexact, exp_v[65:2], exp_v[1], exp_v[0]);
    end
  endtask

  task automatic expect_val(input logic [63:0] op, input logic [1:0] rm,
                            input logic [63:0] er, input logic ei, input logic ex, input string tag);
    @(negedge clk);
    operand = op; rmode = rm;
    @(negedge clk);
    checks++;
    if (result !== er || invalid !== ei || inexact !== ex) begin
      fails++;
      $display("FAIL %s op=%h rm=%0d got %h/%b/%b exp %h/%b/%b",
               tag, op, rm, result, invalid, inexact, er, ei, ex);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    operand = 64'h7FF0_0000_0000_0000;
    repeat (3) @(negedge clk);
    checks++;
    if (result !== 64'd0 || invalid !== 1'b0 || inexact !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset got %h/%b/%b exp 0/0/0", result, invalid, inexact);
    end
    rst_n = 1'b1;

    expect_val(64'h4004_0000_0000_0000, 2'b00, 64'd2, 1'b0, 1'b1, "R2 2.5 nearest");
    expect_val(64'h4004_0000_0000_0000, 2'b01, 64'd2, 1'b0, 1'b1, "R2 2.5 down");
    expect_val(64'h4004_0000_0000_0000, 2'b10, 64'd3, 1'b0, 1'b1, "R2 2.5 up");
    expect_val(64'h4004_0000_0000_0000, 2'b11, 64'd2, 1'b0, 1'b1, "R2 2.5 trunc");
    expect_val(64'h400C_0000_0000_0000, 2'b00, 64'd4, 1'b0, 1'b1, "R2 3.5 nearest");
    expect_val(64'h3FF8_0000_0000_0000, 2'b00, 64'd2, 1'b0, 1'b1, "R2 1.5 nearest");
    expect_val(64'h7FF0_0000_0000_0000, 2'b00, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b0, "R4 +inf");
    expect_val(64'hFFF0_0000_0000_0000, 2'b11, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b0, "R4 -inf");
    expect_val(64'h7FF8_0000_0000_0001, 2'b10, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b0, "R4 nan R3");
    expect_val(64'h43F0_0000_0000_0000, 2'b00, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b0, "R5 2^64");
    expect_val(64'h43EF_FFFF_FFFF_FFFF, 2'b10, 64'hFFFF_FFFF_FFFF_F800, 1'b0, 1'b0, "R5 max exact");
    expect_val(64'hBFD3_3333_3333_3333, 2'b00, 64'd0, 1'b0, 1'b1, "R6 -0.3 nearest");
    expect_val(64'hBFD3_3333_3333_3333, 2'b11, 64'd0, 1'b0, 1'b1, "R6 -0.3 trunc");
    expect_val(64'hBFD3_3333_3333_3333, 2'b01, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b0, "R6 -0.3 down");
    expect_val(64'hBFF0_0000_0000_0000, 2'b11, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b0, "R6 -1.0");
    expect_val(64'h8000_0000_0000_0000, 2'b01, 64'd0, 1'b0, 1'b0, "R7 -0");
    expect_val(64'h0000_0000_0000_0000, 2'b10, 64'd0, 1'b0, 1'b0, "R7 +0");
    expect_val(64'h0000_0000_0000_0001, 2'b00, 64'd0, 1'b0, 1'b1, "R7 subnormal nearest");
    expect_val(64'h0000_0000_0000_0001, 2'b10, 64'd1, 1'b0, 1'b1, "R7 subnormal up");
    expect_val(64'h8000_0000_0000_0001, 2'b01, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b0, "R7 neg subnormal down");
    expect_val(64'h3FE0_0000_0000_0000, 2'b00, 64'd0, 1'b0, 1'b1, "R8 0.5 tie");
    expect_val(64'h4330_0000_0000_0001, 2'b00, 64'h0010_0000_0000_0001, 1'b0, 1'b0, "R9 2^52+1");
    expect_val(64'h43E0_0000_0000_0000, 2'b01, 64'h8000_0000_0000_0000, 1'b0, 1'b0, "R9 2^63");
    expect_val(64'h4059_0000_0000_0000, 2'b10, 64'd100, 1'b0, 1'b0, "R9 100");

    for (int k = 0; k < 3000; k++) begin
      logic [63:0] op;
      op = {$urandom, $urandom};
      if (k % 4 != 0) op[62:52] = 11'd1000 + 11'($urandom_range(0, 90));
      apply(op, 2'($urandom_range(0, 3)), "R2/R5/R8/R9 random");
    end
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired got running exp done");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule